// File: doc/BRIEF.md
# HDLC Data Link Transmit Formatter

This block turns message bytes written by a processor into an HDLC bit stream for a slow terminal data link. The link rides in overhead bit positions of a framer. The framer raises `slot_strobe` once for every data-link bit position. The formatter moves forward by exactly one bit on each strobe and holds its state and output between strobes.

Bytes go into a 16-entry FIFO. Each byte carries a flag that marks it as the last byte of its message. When the FIFO has nothing to send, the block sends flags back to back. A message opens at a flag boundary. The block inserts a zero after any run of five ones. If enabled, it appends a 16-bit check sequence, and it then closes the message with a flag. An abort request, or a FIFO that runs dry in the middle of a message, ends the message with sixteen ones. When the link is disabled, every bit position carries a one.

Top module: `hdlc_tx_fmt`

## Requirements
- R1: While reset is active and afterwards until the first strobe, `tx_bit` is 1, `fifo_empty` is 1, and `fifo_full`, `ovf_flag` and `unf_flag` are 0.
- R2: `tx_bit` and all framing state change only on clock edges where `slot_strobe` is high, and each strobe emits exactly one bit.
- R3: A strobe that finds `link_en` low emits 1 and returns the engine to the start of a flag. The first strobe after re-enabling emits the first bit of a flag.
- R4: Idle output repeats the flag byte 0x7E, sent LSB first (0,1,1,1,1,1,1,0). A message starts only after a complete flag. Consecutive queued messages are separated by exactly one flag.
- R5: Payload bytes are sent LSB first. After five consecutive 1s in the payload or check sequence, a 0 is inserted in its own slot. A zero still owed after the final bit is sent before the closing flag. Flags and abort runs are never stuffed.
- R6: If `fcs_en` is high when the last payload bit is sent, 16 check bits follow. They come from a register preset to 0xFFFF that is updated LSB first on each unstuffed payload bit with the reflected generator 0x8408 (x^16+x^12+x^5+1). The ones complement of the register is sent LSB first. If `fcs_en` is low, the closing flag follows the payload directly.
- R7: A byte written with `wr_eom`=1 is the last byte of its message.
- R8: An `abort_req` pulse is held until the next strobe. If a payload or check bit would be sent on that strobe, sixteen 1s are sent from that strobe on, the FIFO is emptied, and flag idle follows. During flags or idle the request has no effect.
- R9: If a non-final byte ends and the FIFO is empty, sixteen 1s are sent followed by flag idle, and the sticky `unf_flag` is set.
- R10: The FIFO holds 16 bytes and shows `fifo_full` and `fifo_empty`. A write to a full FIFO is discarded and sets the sticky `ovf_flag`.
- R11: A write that lands in the same clock as the strobe that starts an abort is kept after the flush and is sent as the next message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_en | input | 1 | Data link enable, sampled on strobes |
| fcs_en | input | 1 | Append check sequence |
| slot_strobe | input | 1 | One pulse per data-link bit slot |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | 8 | Byte to queue |
| wr_eom | input | 1 | Byte is last of message |
| abort_req | input | 1 | Request abort of current message |
| tx_bit | output | 1 | Serial data-link bit |
| fifo_full | output | 1 | FIFO holds 16 bytes |
| fifo_empty | output | 1 | FIFO holds no bytes |
| ovf_flag | output | 1 | Sticky: write dropped while full |
| unf_flag | output | 1 | Sticky: FIFO ran dry mid-message |

## Verification
The flush that an abort performs can land in the same clock as a processor write. That write belongs to the next message and must survive the flush. The bench provokes this by raising `abort_req`, `slot_strobe` and `wr_en` together while a payload bit is due. It then checks that the sixteen-one run is followed by a flag and by the written byte framed as a complete message. The byte's own bits are expected there, computed in the bench from the requirements. Sweeps over every single-byte value, over message lengths up to a full FIFO, and over back-to-back, underrun and overflow cases are compared bit for bit against streams built in the bench.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] FLAG_BYTE = 8'h7E;
  localparam int FCS_W = 16;
  localparam logic [FCS_W-1:0] FCS_POLY_REFL = 16'h8408;
  localparam int STUFF_RUN = 5;
  localparam int ABORT_LEN = 16;
  localparam int SEQ_MAX = (FCS_W > ABORT_LEN) ? FCS_W : ABORT_LEN;
  localparam int CNT_W = $clog2(SEQ_MAX);
  localparam int RUN_W = $clog2(STUFF_RUN + 1);
  localparam int BIT_IW = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    ST_FLAG  = 2'd0,
    ST_DATA  = 2'd1,
    ST_FCS   = 2'd2,
    ST_ABORT = 2'd3
  } tx_state_e;
endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         flush,
  input  logic         pop,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty,
  output logic         ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d, waddr;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          wr_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign wr_ok   = wr_en & (flush | ~full);
  assign pop_ok  = pop & ~empty & ~flush;
  assign waddr   = flush ? '0 : wp_q;
  assign rd_data = mem[rp_q];
  assign ovf     = ovf_q;

  always_comb begin
    if (flush) begin
      rp_d  = '0;
      wp_d  = wr_ok ? AW'(1) : '0;
      cnt_d = wr_ok ? CW'(1) : '0;
    end else begin
      wp_d  = wp_q + AW'(wr_ok);
      rp_d  = rp_q + AW'(pop_ok);
      cnt_d = cnt_q + CW'(wr_ok) - CW'(pop_ok);
    end
    ovf_d = ovf_q | (wr_en & ~flush & full);
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[waddr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  p_drop_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !flush && !pop) |=> full);
  p_ovf_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !flush) |=> ovf);
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_flush_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && wr_en) |=> (!empty && !full));
endmodule

// File: rtl/hdlc_tx_fcs.sv
module hdlc_tx_fcs #(
  parameter int           W    = 16,
  parameter logic [W-1:0] POLY = 16'h8408
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init,
  input  logic         adv,
  input  logic         bit_in,
  output logic [W-1:0] crc
);
  logic [W-1:0] crc_q, crc_d, step;
  logic         fb;

  assign fb = crc_q[0] ^ bit_in;

  generate
    for (genvar i = 0; i < W; i++) begin : g_tap
      if (i == W - 1) begin : g_top
        assign step[i] = fb & POLY[i];
      end else begin : g_mid
        assign step[i] = crc_q[i+1] ^ (fb & POLY[i]);
      end
    end
  endgenerate

  always_comb begin
    crc_d = crc_q;
    if (init)     crc_d = '1;
    else if (adv) crc_d = step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           crc_q <= '1;
    else if (init | adv)  crc_q <= crc_d;
  end

  assign crc = crc_q;
endmodule

// File: rtl/hdlc_tx_fmt.sv
module hdlc_tx_fmt
  import hdlc_tx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       link_en,
  input  logic       fcs_en,
  input  logic       slot_strobe,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       wr_eom,
  input  logic       abort_req,
  output logic       tx_bit,
  output logic       fifo_full,
  output logic       fifo_empty,
  output logic       ovf_flag,
  output logic       unf_flag
);
  localparam int ENTRY_W = BYTE_W + 1;
  localparam logic [CNT_W-1:0] FLAG_END = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FCS_END  = CNT_W'(FCS_W - 1);
  localparam logic [CNT_W-1:0] ABT_END  = CNT_W'(ABORT_LEN - 1);
  localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(STUFF_RUN);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rs_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  tx_state_e          st_q, st_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [RUN_W-1:0]   ones_q, ones_d;
  logic [BYTE_W-1:0]  sh_q, sh_d;
  logic               last_q, last_d;
  logic               tx_q, tx_d;
  logic               pend_q, pend_d;
  logic               unf_q, unf_d;
  logic               abort_any, pop, flush, fcs_init, fcs_adv;
  logic [ENTRY_W-1:0] f_rd;
  logic               f_full, f_empty;
  logic [FCS_W-1:0]   crc;

  hdlc_tx_fifo #(.DEPTH(FIFO_DEPTH), .W(ENTRY_W)) u_fifo (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_en   (wr_en),
    .wr_data ({wr_eom, wr_data}),
    .flush   (flush),
    .pop     (pop),
    .rd_data (f_rd),
    .full    (f_full),
    .empty   (f_empty),
    .ovf     (ovf_flag)
  );

  hdlc_tx_fcs #(.W(FCS_W), .POLY(FCS_POLY_REFL)) u_fcs (
    .clk    (clk),
    .rst_n  (srst_n),
    .init   (fcs_init),
    .adv    (fcs_adv),
    .bit_in (sh_q[0]),
    .crc    (crc)
  );

  assign abort_any = pend_q | abort_req;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    ones_d   = ones_q;
    sh_d     = sh_q;
    last_d   = last_q;
    tx_d     = tx_q;
    unf_d    = unf_q;
    pend_d   = pend_q | abort_req;
    pop      = 1'b0;
    flush    = 1'b0;
    fcs_init = 1'b0;
    fcs_adv  = 1'b0;
    if (slot_strobe) begin
      pend_d = 1'b0;
      if (!link_en) begin
        tx_d   = 1'b1;
        st_d   = ST_FLAG;
        cnt_d  = '0;
        ones_d = '0;
      end else begin
        unique case (st_q)
          ST_FLAG: begin
            if (ones_q == RUN_FULL) begin
              tx_d   = 1'b0;
              ones_d = '0;
            end else begin
              tx_d   = FLAG_BYTE[cnt_q[BIT_IW-1:0]];
              ones_d = '0;
              if (cnt_q == FLAG_END) begin
                cnt_d = '0;
                if (!f_empty) begin
                  pop      = 1'b1;
                  sh_d     = f_rd[BYTE_W-1:0];
                  last_d   = f_rd[BYTE_W];
                  fcs_init = 1'b1;
                  st_d     = ST_DATA;
                end
              end else begin
                cnt_d = cnt_q + 1'b1;
              end
            end
          end
          ST_DATA: begin
            if (abort_any) begin
              tx_d   = 1'b1;
              flush  = 1'b1;
              st_d   = ST_ABORT;
              cnt_d  = CNT_W'(1);
              ones_d = '0;
            end else if (ones_q == RUN_FULL) begin
              tx_d   = 1'b0;
              ones_d = '0;
            end else begin
              tx_d    = sh_q[0];
              fcs_adv = 1'b1;
              ones_d  = sh_q[0] ? ones_q + 1'b1 : '0;
              sh_d    = sh_q >> 1;
              if (cnt_q == BYTE_END) begin
                cnt_d = '0;
                if (last_q) begin
                  st_d = fcs_en ? ST_FCS : ST_FLAG;
                end else if (f_empty) begin
                  st_d  = ST_ABORT;
                  unf_d = 1'b1;
                end else begin
                  pop    = 1'b1;
                  sh_d   = f_rd[BYTE_W-1:0];
                  last_d = f_rd[BYTE_W];
                end
              end else begin
                cnt_d = cnt_q + 1'b1;
              end
            end
          end
          ST_FCS: begin
            if (abort_any) begin
              tx_d   = 1'b1;
              flush  = 1'b1;
              st_d   = ST_ABORT;
              cnt_d  = CNT_W'(1);
              ones_d = '0;
            end else if (ones_q == RUN_FULL) begin
              tx_d   = 1'b0;
              ones_d = '0;
            end else begin
              tx_d   = ~crc[cnt_q];
              ones_d = ~crc[cnt_q] ? ones_q + 1'b1 : '0;
              if (cnt_q == FCS_END) begin
                cnt_d = '0;
                st_d  = ST_FLAG;
              end else begin
                cnt_d = cnt_q + 1'b1;
              end
            end
          end
          ST_ABORT: begin
            tx_d   = 1'b1;
            ones_d = '0;
            if (cnt_q == ABT_END) begin
              cnt_d = '0;
              st_d  = ST_FLAG;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q   <= ST_FLAG;
      cnt_q  <= '0;
      ones_q <= '0;
      sh_q   <= '0;
      last_q <= 1'b0;
      tx_q   <= 1'b1;
      unf_q  <= 1'b0;
    end else if (slot_strobe) begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      ones_q <= ones_d;
      sh_q   <= sh_d;
      last_q <= last_d;
      tx_q   <= tx_d;
      unf_q  <= unf_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  assign tx_bit     = tx_q;
  assign fifo_full  = f_full;
  assign fifo_empty = f_empty;
  assign unf_flag   = unf_q;

  p_hold_r2: assert property (@(posedge clk) disable iff (!srst_n)
    !slot_strobe |=> $stable(tx_bit));
  p_disabled_one_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (slot_strobe && !link_en) |=> (tx_bit && st_q == ST_FLAG && cnt_q == '0));
  p_stuff_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (slot_strobe && link_en && !abort_any && st_q != ST_ABORT && ones_q == RUN_FULL)
      |=> (!tx_bit && ones_q == '0));
  p_abort_start_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (slot_strobe && link_en && abort_any && (st_q == ST_DATA || st_q == ST_FCS))
      |=> (tx_bit && st_q == ST_ABORT));
  p_unf_sticky_r9: assert property (@(posedge clk) disable iff (!srst_n)
    unf_flag |=> unf_flag);
  p_abort_run_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (st_q == ST_ABORT && cnt_q != '0) |-> tx_bit);
endmodule

// File: tb/hdlc_tx_fmt_bench.sv
module hdlc_tx_fmt_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, link_en = 1'b0, fcs_en = 1'b0, slot_strobe = 1'b0;
  logic wr_en = 1'b0, wr_eom = 1'b0, abort_req = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic tx_bit, fifo_full, fifo_empty, ovf_flag, unf_flag;

  hdlc_tx_fmt u_hdlc_tx_fmt (
    .clk(clk), .rst_n(rst_n), .link_en(link_en), .fcs_en(fcs_en),
    .slot_strobe(slot_strobe), .wr_en(wr_en), .wr_data(wr_data),
    .wr_eom(wr_eom), .abort_req(abort_req), .tx_bit(tx_bit),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  int n_run = 0, n_fail = 0, stab_err = 0;
  bit ex [0:4095];
  int en = 0;
  int ones = 0;
  logic [7:0] msg [0:31];

  task automatic check(input bit ok, input string tag, input int act, input int exp_v);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
    end
  endtask

  task automatic strobe(output logic b);
    @(negedge clk) slot_strobe = 1'b1;
    @(negedge clk) slot_strobe = 1'b0;
    b = tx_bit;
    @(negedge clk);
    if (tx_bit !== b) stab_err++;
  endtask

  task automatic wr(input logic [7:0] d, input logic e);
    @(negedge clk) begin wr_en = 1'b1; wr_data = d; wr_eom = e; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic push(input bit b);
    ex[en] = b;
    en++;
  endtask

  task automatic push_flag();
    for (int i = 0; i < 8; i++) push(((8'h7E >> i) & 8'h01) != 0);
    ones = 0;
  endtask

  task automatic push_st(input bit b);
    if (ones == 5) begin push(1'b0); ones = 0; end
    push(b);
    ones = b ? ones + 1 : 0;
  endtask

  task automatic push_ones16();
    for (int i = 0; i < 16; i++) push(1'b1);
    ones = 0;
  endtask

  function automatic logic [15:0] crc_step(input logic [15:0] c, input bit b);
    return (c[0] ^ b) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
  endfunction

  task automatic push_msg(input int len, input bit fcs);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < len; k++)
      for (int i = 0; i < 8; i++) begin
        push_st(msg[k][i]);
        c = crc_step(c, msg[k][i]);
      end
    if (fcs) begin
      c = ~c;
      for (int i = 0; i < 16; i++) push_st(c[i]);
    end
    if (ones == 5) push(1'b0);
    push_flag();
  endtask

  task automatic compare(input string tag);
    logic b;
    int bad = -1;
    int bv = 0;
    for (int i = 0; i < en; i++) begin
      strobe(b);
      if (b !== ex[i] && bad < 0) begin bad = i; bv = int'(b); end
    end
    if (bad >= 0) check(1'b0, $sformatf("%s bit %0d", tag, bad), bv, int'(ex[bad]));
    else          check(1'b1, tag, 0, 0);
    en = 0;
  endtask

  task automatic park();
    logic b;
    @(negedge clk) link_en = 1'b0;
    strobe(b);
    en = 0;
    ones = 0;
  endtask

  initial begin
    logic b;
    int cnt1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(tx_bit === 1'b1 && fifo_empty === 1'b1 && fifo_full === 1'b0 &&
          ovf_flag === 1'b0 && unf_flag === 1'b0, "R1 reset outputs", int'(tx_bit), 1);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(tx_bit === 1'b1 && fifo_empty === 1'b1, "R1 after release", int'(tx_bit), 1);

    // R3 disabled: every slot carries 1
    cnt1 = 0;
    for (int i = 0; i < 6; i++) begin strobe(b); if (b === 1'b1) cnt1++; end
    check(cnt1 == 6, "R3 disabled ones", cnt1, 6);

    // R4 idle flags
    @(negedge clk) link_en = 1'b1;
    push_flag(); push_flag(); push_flag();
    compare("R4 idle flags");
    park();
    @(negedge clk) link_en = 1'b1;
    push_flag();
    compare("R3 restart at flag start");

    // R5 R6 R7: every single-byte message, check sequence on odd values
    for (int v = 0; v < 256; v++) begin
      park();
      msg[0] = 8'(v);
      wr(8'(v), 1'b1);
      @(negedge clk) begin fcs_en = v[0]; link_en = 1'b1; end
      push_flag(); push_msg(1, v[0]); push_flag();
      compare($sformatf("R5 R6 R7 byte %0d", v));
    end

    // R5 R7: lengths 2..16 with long runs of ones
    for (int len = 2; len <= 16; len++) begin
      park();
      for (int k = 0; k < len; k++) begin
        msg[k] = (k % 3 == 0) ? 8'hFF : 8'(k * 53 + len * 7);
        wr(msg[k], k == len - 1);
      end
      @(negedge clk) begin fcs_en = len[0]; link_en = 1'b1; end
      push_flag(); push_msg(len, len[0]); push_flag();
      compare($sformatf("R5 R7 length %0d", len));
    end

    // R4 back-to-back messages share one flag
    park();
    msg[0] = 8'hFF; msg[1] = 8'hF8;
    wr(msg[0], 1'b0); wr(msg[1], 1'b1);
    @(negedge clk) begin fcs_en = 1'b1; link_en = 1'b1; end
    push_flag(); push_msg(2, 1'b1);
    msg[0] = 8'h12; msg[1] = 8'h7E; msg[2] = 8'h3F;
    wr(msg[0], 1'b0); wr(msg[1], 1'b0); wr(msg[2], 1'b1);
    push_msg(3, 1'b1); push_flag();
    compare("R4 back-to-back");

    // R9 underrun
    park();
    check(unf_flag === 1'b0, "R9 clear before", int'(unf_flag), 0);
    wr(8'h3C, 1'b0); wr(8'h55, 1'b0);
    @(negedge clk) link_en = 1'b1;
    msg[0] = 8'h3C; msg[1] = 8'h55;
    push_flag();
    for (int k = 0; k < 2; k++) for (int i = 0; i < 8; i++) push_st(msg[k][i]);
    push_ones16(); push_flag(); push_flag();
    compare("R9 underrun stream");
    check(unf_flag === 1'b1, "R9 sticky set", int'(unf_flag), 1);

    // R8 abort request mid-payload flushes FIFO
    park();
    for (int k = 0; k < 4; k++) wr(8'h00, k == 3);
    @(negedge clk) begin fcs_en = 1'b1; link_en = 1'b1; end
    push_flag(); for (int i = 0; i < 4; i++) push_st(1'b0);
    compare("R8 before abort");
    @(negedge clk) abort_req = 1'b1;
    @(negedge clk) abort_req = 1'b0;
    push_ones16(); push_flag(); push_flag();
    compare("R8 abort run");
    check(fifo_empty === 1'b1, "R8 fifo flushed", int'(fifo_empty), 1);

    // R8 abort during idle flags has no effect
    @(negedge clk) abort_req = 1'b1;
    @(negedge clk) abort_req = 1'b0;
    push_flag(); push_flag();
    compare("R8 idle abort ignored");

    // R11 write in the same clock as the abort-taking strobe
    park();
    for (int k = 0; k < 3; k++) wr(8'h00, k == 2);
    @(negedge clk) begin fcs_en = 1'b0; link_en = 1'b1; end
    push_flag(); for (int i = 0; i < 4; i++) push_st(1'b0);
    compare("R11 before abort");
    @(negedge clk) begin
      abort_req = 1'b1; slot_strobe = 1'b1;
      wr_en = 1'b1; wr_data = 8'hA5; wr_eom = 1'b1;
    end
    @(negedge clk) begin abort_req = 1'b0; slot_strobe = 1'b0; wr_en = 1'b0; end
    check(tx_bit === 1'b1, "R11 first abort bit", int'(tx_bit), 1);
    @(negedge clk);
    for (int i = 0; i < 15; i++) push(1'b1);
    ones = 0;
    push_flag(); msg[0] = 8'hA5; push_msg(1, 1'b0); push_flag();
    compare("R11 kept byte framed");

    // R10 overflow
    park();
    for (int k = 0; k < 16; k++) begin msg[k] = 8'(k * 17 + 3); wr(msg[k], k == 15); end
    check(fifo_full === 1'b1 && ovf_flag === 1'b0, "R10 full no ovf", int'(fifo_full), 1);
    wr(8'hEE, 1'b1);
    check(ovf_flag === 1'b1 && fifo_full === 1'b1, "R10 ovf sticky", int'(ovf_flag), 1);
    @(negedge clk) begin fcs_en = 1'b1; link_en = 1'b1; end
    push_flag(); push_msg(16, 1'b1); push_flag(); push_flag();
    compare("R10 dropped byte absent");
    check(fifo_empty === 1'b1 && ovf_flag === 1'b1, "R10 drained", int'(fifo_empty), 1);

    // R2 output held between strobes
    check(stab_err == 0, "R2 stable between strobes", stab_err, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule